// File: doc/BRIEF.md
# Masked Interrupt Latch with Acknowledge Readout

This block collects interrupt events from three sources into an 8-bit pending register and drives one active-low interrupt line toward the host. The three sources are a free-running one-second tick, a peripheral-bus reply becoming ready, and a periodic bus autopoll. An 8-bit enable mask selects which pending bits may pull the line low. The host replaces the mask with a one-byte command. It reads and clears events with an acknowledge command, whose response comes back as a byte stream.

When a bus reply is waiting, the acknowledge response starts with the bus-related pending bits. The stored reply payload follows in the same stream. Only those bus bits are cleared, and the payload store is emptied for the next reply. With no reply waiting, the response is a single byte holding the whole pending register, and nothing is cleared. Millisecond timing comes from a clock-cycle prescaler, so both the tick and the autopoll periods scale with one parameter.

Top module: `irq_latch_ack`

## Requirements
- R1: While reset is held, `irq_n` is 1 and `rsp_valid` is 0.
- R2: After reset the mask is 0x09, so only the reply bit (bit 0) and the tick bit (bit 3) can assert the line.
- R3: `irq_n` is 0 exactly when (pending AND mask) is nonzero. It changes on the same clock edge as the pending or mask change that causes it.
- R4: A mask write with `mask_nargs` = 1 replaces the mask with `mask_byte`. A write with any other argument count leaves the mask unchanged.
- R5: An acknowledge accepted while bit 0 is pending returns a head byte equal to pending AND 0x05, followed by the stored payload bytes in push order. Bits 0 and 2 are then cleared, and the stored reply length becomes zero.
- R6: An acknowledge accepted while bit 0 is clear returns one byte holding the full pending register, with `rsp_last` set. No pending bit is cleared.
- R7: An acknowledge is ignored, producing no response, when `ack_nargs` is nonzero or while an earlier response is still streaming.
- R8: The tick sets pending bit 3 on clock edge CYCLES_PER_MS*TICK_MS after reset release, and then every CYCLES_PER_MS*TICK_MS edges with no drift.
- R9: Every POLL_MS milliseconds, if `poll_ready` is 1 and bit 0 is clear, the autopoll sets bits 0 and 2. Otherwise the autopoll changes nothing.
- R10: Payload pushes beyond DEPTH bytes are dropped. Pushes made while a response is streaming, or in the cycle an acknowledge is accepted, are also dropped.
- R11: A response is one byte per cycle with `rsp_valid` high. The first byte appears on the edge that accepts the acknowledge, and `rsp_last` marks the final byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reply_push | input | 1 | Append `reply_byte` to the reply payload store |
| reply_byte | input | 8 | Payload byte |
| reply_done | input | 1 | Pulse: a bus reply is ready; sets bit 0 |
| poll_ready | input | 1 | Autopoll has data to report |
| mask_wr | input | 1 | Mask command strobe |
| mask_nargs | input | 4 | Argument count of the mask command |
| mask_byte | input | 8 | New mask value |
| ack_req | input | 1 | Acknowledge command strobe |
| ack_nargs | input | 4 | Argument count of the acknowledge command |
| rsp_valid | output | 1 | Response byte valid |
| rsp_data | output | 8 | Response byte |
| rsp_last | output | 1 | Final byte of a response |
| irq_n | output | 1 | Active-low interrupt line |

## Verification
The bench times the first tick to the exact edge. A prescaler or interval off by one would show up as a tick one cycle early or late. It also measures the spacing between two autopoll events, which catches a counter that drifts or restarts at the wrong point. Acknowledges are run with payloads of zero, one, several and more than DEPTH bytes. A design that reported the tick bit in the head byte, or that cleared it, would then return 0x09 or lose 0x08. A design that overran the store, or left the stored length in place, would return extra bytes on the next acknowledge. Further cases are a second acknowledge held during streaming, a push made during streaming, mask commands with a wrong argument count, and a mid-run reset. These would expose a response that restarts, a payload that is corrupted, or a mask that takes illegal writes or fails to return to 0x09.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;
    localparam int         BIT_REPLY  = 0;
    localparam int         BIT_POLL   = 2;
    localparam int         BIT_TICK   = 3;
    localparam logic [7:0] BUS_BITS   = 8'h05;
    localparam logic [7:0] MASK_RESET = 8'h09;
endpackage

// File: rtl/ila_ms_strobe.sv
module ila_ms_strobe #(
    parameter int CYCLES_PER_MS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    output logic ms_tick
);
    localparam int W = $clog2(CYCLES_PER_MS + 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        ms_tick = (cnt_q == W'(CYCLES_PER_MS - 1));
        cnt_d   = ms_tick ? '0 : cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/ila_interval.sv
module ila_interval #(
    parameter int PERIOD_MS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ms_tick,
    output logic fire
);
    localparam int W = $clog2(PERIOD_MS + 1);

    logic [W-1:0] cnt_d, cnt_q;
    logic         wrap;

    always_comb begin
        wrap  = (cnt_q == W'(PERIOD_MS - 1));
        fire  = ms_tick && wrap;
        cnt_d = cnt_q;
        if (ms_tick) cnt_d = wrap ? '0 : cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/ila_reply_store.sv
module ila_reply_store #(
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [7:0]       wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [7:0]       rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[widx] <= wdata;
    end

    assign rdata = mem[ridx];
endmodule

// File: rtl/irq_latch_ack.sv
module irq_latch_ack #(
    parameter int CYCLES_PER_MS = 1000,
    parameter int TICK_MS       = 1000,
    parameter int POLL_MS       = 30,
    parameter int DEPTH         = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reply_push,
    input  logic [7:0] reply_byte,
    input  logic       reply_done,
    input  logic       poll_ready,
    input  logic       mask_wr,
    input  logic [3:0] mask_nargs,
    input  logic [7:0] mask_byte,
    input  logic       ack_req,
    input  logic [3:0] ack_nargs,
    output logic       rsp_valid,
    output logic [7:0] rsp_data,
    output logic       rsp_last,
    output logic       irq_n
);
    import irq_latch_pkg::*;

    localparam int LEN_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [7:0]       pend;
        logic [7:0]       mask;
        logic             irq_n;
        logic             rsp_valid;
        logic [7:0]       rsp_data;
        logic             rsp_last;
        logic [LEN_W-1:0] rsp_left;
        logic [IDX_W-1:0] rd_idx;
        logic [LEN_W-1:0] reply_len;
    } state_t;

    state_t st_d, st_q;

    logic       ms_tick, tick_fire, poll_fire;
    logic       busy, ack_ok, push_ok, poll_set;
    logic [7:0] rd_data;

    // signals observed by the bound checker
    logic [7:0]       pend_q, mask_q;
    logic [LEN_W-1:0] reply_len_q, rsp_left_q;
    assign pend_q      = st_q.pend;
    assign mask_q      = st_q.mask;
    assign reply_len_q = st_q.reply_len;
    assign rsp_left_q  = st_q.rsp_left;

    ila_ms_strobe #(.CYCLES_PER_MS(CYCLES_PER_MS)) u_ms (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick)
    );

    ila_interval #(.PERIOD_MS(TICK_MS)) u_tick (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .fire(tick_fire)
    );

    ila_interval #(.PERIOD_MS(POLL_MS)) u_poll (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .fire(poll_fire)
    );

    ila_reply_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk),
        .we(push_ok),
        .widx(st_q.reply_len[IDX_W-1:0]),
        .wdata(reply_byte),
        .ridx(st_q.rd_idx),
        .rdata(rd_data)
    );

    always_comb begin
        busy     = (st_q.rsp_left != '0);
        ack_ok   = ack_req && !busy && (ack_nargs == 4'd0);
        push_ok  = reply_push && !busy && !ack_ok && (st_q.reply_len < LEN_W'(DEPTH));
        poll_set = poll_fire && poll_ready && !st_q.pend[BIT_REPLY];

        st_d           = st_q;
        st_d.rsp_valid = 1'b0;
        st_d.rsp_last  = 1'b0;
        st_d.rsp_data  = '0;

        if (mask_wr && (mask_nargs == 4'd1)) st_d.mask = mask_byte;

        if (push_ok) st_d.reply_len = st_q.reply_len + LEN_W'(1);

        if (busy) begin
            st_d.rsp_valid = 1'b1;
            st_d.rsp_data  = rd_data;
            st_d.rsp_last  = (st_q.rsp_left == LEN_W'(1));
            st_d.rsp_left  = st_q.rsp_left - LEN_W'(1);
            st_d.rd_idx    = st_q.rd_idx + IDX_W'(1);
        end else if (ack_ok) begin
            st_d.rsp_valid = 1'b1;
            if (st_q.pend[BIT_REPLY]) begin
                st_d.rsp_data  = st_q.pend & BUS_BITS;
                st_d.rsp_left  = st_q.reply_len;
                st_d.rsp_last  = (st_q.reply_len == '0);
                st_d.rd_idx    = '0;
                st_d.reply_len = '0;
                st_d.pend      = st_q.pend & ~BUS_BITS;
            end else begin
                st_d.rsp_data = st_q.pend;
                st_d.rsp_last = 1'b1;
            end
        end

        // new events win over a clear in the same cycle
        if (reply_done) st_d.pend[BIT_REPLY] = 1'b1;
        if (poll_set) begin
            st_d.pend[BIT_REPLY] = 1'b1;
            st_d.pend[BIT_POLL]  = 1'b1;
        end
        if (tick_fire) st_d.pend[BIT_TICK] = 1'b1;

        st_d.irq_n = ~|(st_d.pend & st_d.mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.mask  <= MASK_RESET;
            st_q.irq_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_data  = st_q.rsp_data;
    assign rsp_last  = st_q.rsp_last;
    assign irq_n     = st_q.irq_n;
endmodule

// File: rtl/irq_latch_chk.sv
module irq_latch_chk #(
    parameter int CYCLES_PER_MS = 1000,
    parameter int TICK_MS       = 1000,
    parameter int DEPTH         = 8,
    parameter int LEN_W         = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       pend_q,
    input logic [7:0]       mask_q,
    input logic             irq_n,
    input logic             mask_wr,
    input logic [3:0]       mask_nargs,
    input logic             ack_ok,
    input logic             reply_done,
    input logic             poll_set,
    input logic             tick_fire,
    input logic             rsp_valid,
    input logic             rsp_last,
    input logic [LEN_W-1:0] reply_len_q,
    input logic [LEN_W-1:0] rsp_left_q
);
    localparam int PERIOD = CYCLES_PER_MS * TICK_MS;

    logic [31:0] since_q;
    logic        seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q <= '0;
            seen_q  <= 1'b0;
        end else begin
            since_q <= tick_fire ? 32'd0 : since_q + 32'd1;
            if (tick_fire) seen_q <= 1'b1;
        end
    end

    a_r3_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
        irq_n == ~|(pend_q & mask_q));

    a_r4_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(mask_wr && mask_nargs == 4'd1) |=> $stable(mask_q));

    a_r5_bus_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_ok && pend_q[0] && !reply_done && !poll_set) |=> (pend_q[0] == 1'b0 && pend_q[2] == 1'b0));

    a_r6_no_loss: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_ok && !pend_q[0]) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

    a_r7_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_left_q != '0) |-> !ack_ok);

    a_r8_tick_period: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_fire && seen_q) |-> (since_q == 32'(PERIOD - 1)));

    a_r10_len_cap: assert property (@(posedge clk) disable iff (!rst_n)
        reply_len_q <= LEN_W'(DEPTH));

    a_r11_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_last |-> rsp_valid);
endmodule

bind irq_latch_ack irq_latch_chk #(
    .CYCLES_PER_MS(CYCLES_PER_MS),
    .TICK_MS(TICK_MS),
    .DEPTH(DEPTH),
    .LEN_W(LEN_W)
) u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .pend_q(pend_q),
    .mask_q(mask_q),
    .irq_n(irq_n),
    .mask_wr(mask_wr),
    .mask_nargs(mask_nargs),
    .ack_ok(ack_ok),
    .reply_done(reply_done),
    .poll_set(poll_set),
    .tick_fire(tick_fire),
    .rsp_valid(rsp_valid),
    .rsp_last(rsp_last),
    .reply_len_q(reply_len_q),
    .rsp_left_q(rsp_left_q)
);

// File: tb/sim_irq_latch_ack.sv
module sim_irq_latch_ack;
    localparam int CLK_P = 10;
    localparam int CPM   = 4;
    localparam int TICKM = 10;
    localparam int POLLM = 3;
    localparam int DEP   = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reply_push = 1'b0;
    logic [7:0] reply_byte = '0;
    logic       reply_done = 1'b0;
    logic       poll_ready = 1'b0;
    logic       mask_wr = 1'b0;
    logic [3:0] mask_nargs = '0;
    logic [7:0] mask_byte = '0;
    logic       ack_req = 1'b0;
    logic [3:0] ack_nargs = '0;
    logic       rsp_valid, rsp_last, irq_n;
    logic [7:0] rsp_data;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    logic [7:0] rbuf [32];
    int         rsp_n;
    bit         got_last;

    // reply vectors: pushes, first byte, expected payload count
    localparam int VN = 4;
    localparam int         V_NPUSH [VN] = '{3, 0, 10, 1};
    localparam logic [7:0] V_BASE  [VN] = '{8'h10, 8'h00, 8'h40, 8'hA0};
    localparam int         V_EXPN  [VN] = '{3, 0, 8, 1};

    irq_latch_ack #(.CYCLES_PER_MS(CPM), .TICK_MS(TICKM), .POLL_MS(POLLM), .DEPTH(DEP)) u0 (
        .clk(clk), .rst_n(rst_n),
        .reply_push(reply_push), .reply_byte(reply_byte), .reply_done(reply_done),
        .poll_ready(poll_ready),
        .mask_wr(mask_wr), .mask_nargs(mask_nargs), .mask_byte(mask_byte),
        .ack_req(ack_req), .ack_nargs(ack_nargs),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_last(rsp_last), .irq_n(irq_n)
    );

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_mask(input logic [3:0] n, input logic [7:0] v);
        @(negedge clk); mask_wr = 1'b1; mask_nargs = n; mask_byte = v;
        @(negedge clk); mask_wr = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk); reply_done = 1'b1;
        @(negedge clk); reply_done = 1'b0;
    endtask

    task automatic push_bytes(input int n, input logic [7:0] base);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); reply_push = 1'b1; reply_byte = base + 8'(k);
        end
        @(negedge clk); reply_push = 1'b0;
    endtask

    task automatic do_ack(input logic [3:0] n);
        @(negedge clk); ack_req = 1'b1; ack_nargs = n;
        @(negedge clk); ack_req = 1'b0; ack_nargs = '0;
        rsp_n = 0; got_last = 1'b0;
        for (int k = 0; k < 20; k++) begin
            if (!rsp_valid) break;
            rbuf[rsp_n] = rsp_data;
            rsp_n++;
            if (rsp_last) begin got_last = 1'b1; break; end
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic wait_irq_low(output int at);
        at = -1;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (!irq_n) begin at = cyc; break; end
        end
    endtask

    initial begin
        #(CLK_P * 50000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int n_first, a_at, b_at;
        // R1: state held in reset
        repeat (3) @(negedge clk);
        chk("R1 irq_n in reset", 32'(irq_n), 32'd1);
        chk("R1 rsp_valid in reset", 32'(rsp_valid), 32'd0);
        rst_n = 1'b1;

        // R8: first tick on edge CPM*TICKM; R2: tick enabled by reset mask
        n_first = 0;
        for (int k = 0; k < 200; k++) begin
            @(posedge clk); n_first++;
            @(negedge clk);
            if (!irq_n) break;
        end
        chk("R8 first tick edge", 32'(n_first), 32'(CPM * TICKM));

        // R6: no reply pending -> single byte of full pending, nothing cleared
        do_ack(4'd0);
        chk("R6 rsp count", 32'(rsp_n), 32'd1);
        chk("R6 rsp byte (R9 no poll without ready)", 32'(rbuf[0]), 32'h08);
        chk("R11 last flag", 32'(got_last), 32'd1);
        chk("R6 tick kept pending", 32'(irq_n), 32'd0);

        // R4 / R3: mask write
        set_mask(4'd1, 8'h00);
        chk("R4 mask zero releases irq (R3)", 32'(irq_n), 32'd1);
        set_mask(4'd2, 8'hFF);
        chk("R4 two-arg write ignored", 32'(irq_n), 32'd1);
        set_mask(4'd0, 8'h08);
        chk("R4 zero-arg write ignored", 32'(irq_n), 32'd1);
        set_mask(4'd1, 8'h01);
        chk("R4 mask 0x01 keeps tick masked", 32'(irq_n), 32'd1);

        // R5 / R10: reply vectors
        for (int v = 0; v < VN; v++) begin
            push_bytes(V_NPUSH[v], V_BASE[v]);
            pulse_done();
            chk("R3 reply asserts irq", 32'(irq_n), 32'd0);
            do_ack(4'd0);
            chk("R5 total bytes (R10 cap)", 32'(rsp_n), 32'(V_EXPN[v] + 1));
            chk("R5 head byte", 32'(rbuf[0]), 32'h01);
            for (int k = 0; k < V_EXPN[v]; k++)
                chk("R5 payload byte", 32'(rbuf[k + 1]), 32'(V_BASE[v] + 8'(k)));
            chk("R11 last on final", 32'(got_last), 32'd1);
            chk("R5 irq released after clear", 32'(irq_n), 32'd1);
            do_ack(4'd0);
            chk("R5 length reset", 32'(rsp_n), 32'd1);
            chk("R5 bus bits cleared", 32'(rbuf[0]), 32'h08);
        end

        // R7: acknowledge with an argument is ignored
        do_ack(4'd1);
        chk("R7 ack with args ignored", 32'(rsp_n), 32'd0);

        // R7 / R10 / R11: ack held during streaming and push during streaming
        push_bytes(4, 8'h30);
        pulse_done();
        @(negedge clk); ack_req = 1'b1; ack_nargs = '0;
        rsp_n = 0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            if (k == 0) begin reply_push = 1'b1; reply_byte = 8'h77; end
            chk("R11 one byte per cycle", 32'(rsp_valid), 32'd1);
            rbuf[rsp_n] = rsp_data; rsp_n++;
            chk("R11 last position", 32'(rsp_last), 32'(k == 4));
        end
        ack_req = 1'b0; reply_push = 1'b0;
        @(negedge clk);
        chk("R7 held ack not restarted", 32'(rsp_valid), 32'd0);
        chk("R5 stream head", 32'(rbuf[0]), 32'h01);
        for (int k = 0; k < 4; k++)
            chk("R5 stream payload", 32'(rbuf[k + 1]), 32'h30 + 32'(k));
        do_ack(4'd0);
        chk("R7 no second response pending bits", 32'(rbuf[0]), 32'h08);
        pulse_done();
        do_ack(4'd0);
        chk("R10 push during stream dropped", 32'(rsp_n), 32'd1);

        // R9: autopoll period and bits
        poll_ready = 1'b1;
        wait_irq_low(a_at);
        chk("R9 autopoll asserted", 32'(a_at >= 0), 32'd1);
        do_ack(4'd0);
        chk("R9 autopoll head", 32'(rbuf[0]), 32'h05);
        chk("R9 autopoll payload empty", 32'(rsp_n), 32'd1);
        chk("R9 irq released", 32'(irq_n), 32'd1);
        wait_irq_low(b_at);
        chk("R9 autopoll period", 32'(b_at - a_at), 32'(CPM * POLLM));
        repeat (CPM * POLLM + 2) @(negedge clk);
        do_ack(4'd0);
        chk("R9 no re-set while pending", 32'(rbuf[0]), 32'h05);
        poll_ready = 1'b0;
        repeat (CPM * POLLM * 2 + 2) @(negedge clk);
        do_ack(4'd0);
        chk("R9 no poll when not ready", 32'(rbuf[0]), 32'h08);

        // R2: mid-run reset restores mask 0x09
        set_mask(4'd1, 8'h00);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk("R1 irq_n after reset", 32'(irq_n), 32'd1);
        rst_n = 1'b1;
        pulse_done();
        chk("R2 reply enabled after reset", 32'(irq_n), 32'd0);
        do_ack(4'd0);
        chk("R2 reply head after reset", 32'(rbuf[0]), 32'h01);
        chk("R2 irq released", 32'(irq_n), 32'd1);
        wait_irq_low(a_at);
        chk("R2 tick enabled after reset", 32'(a_at >= 0), 32'd1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule